// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block maps the four active-low PCI interrupt lines onto a 16-bit legacy IRQ request vector for an interrupt controller. Two byte-wide routing registers are loaded through a write strobe with an address. Each register holds two 4-bit route fields, one per PCI line. The low three bits of a field choose one of seven IRQ targets, or none. The top bit asks for the selected target to be driven as an edge rather than a level.

Lines that share a target are combined into one request. A level-mode target presents the combined request as a level. An edge-mode target gives a single-clock pulse each time the combined request rises. Only seven IRQ numbers can ever be driven; the other bits of the vector stay at zero.

Top module: `pirq_steer`

## Requirements
- R1: After reset the register at address ROUTE_ADDR holds 0x80 and the register at ROUTE_ADDR+1 holds 0x00, so every line is disabled and `irq_req` stays zero even with all four lines asserted.
- R2: A write with `wr_en` high to ROUTE_ADDR or ROUTE_ADDR+1 loads `wr_data` into that register, and the new routing is seen on `irq_req` one clock after the write edge. Writes to any other address leave the routing unchanged.
- R3: Field layout: bits [3:0] of register ROUTE_ADDR route line A (`pci_int_n[0]`) and bits [7:4] route line B (`pci_int_n[1]`). Bits [3:0] of ROUTE_ADDR+1 route line C (`pci_int_n[2]`) and bits [7:4] route line D (`pci_int_n[3]`).
- R4: Field bits [2:0] select the target: 0 gives none, then 1 gives IRQ5, 2 gives IRQ9, 3 gives IRQ10, 4 gives IRQ11, 5 gives IRQ12, 6 gives IRQ14 and 7 gives IRQ15.
- R5: A field whose index is 0 adds nothing to any output, whatever its bit 3.
- R6: A PCI line is asserted when its input is 0. All asserted lines that route to one target are ORed into that target's combined request.
- R7: A target is in edge mode when any field selecting it has bit 3 set, and is in level mode otherwise. In level mode, `irq_req[k]` equals the combined request sampled at the previous clock edge.
- R8: In edge mode, a 0-to-1 change of the combined request gives `irq_req[k]` high for exactly one clock. A request held high, or a second line joining a request that is already high, gives no further pulse.
- R9: Bits of `irq_req` other than 5, 9, 10, 11, 12, 14 and 15 are always 0.
- R10: When the route of an asserted line is rewritten to index 0, its target drops to 0 one clock after the write edge and gives no later pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data |
| pci_int_n | input | 4 | PCI interrupt lines A to D, active low |
| irq_req | output | 16 | IRQ request vector, bit k is IRQ k |

## Verification
The main test walks the value of the first routing register through all 256 codes. The second register takes a value derived from the first. Every configuration is tried with all 16 patterns of asserted lines. The first sample after a pattern is applied separates correct target decode and OR-combining from wrong ones. The second sample separates level targets, which hold, from edge targets, which must have returned to zero. The release sample shows that nothing lingers. Directed cases cover the reset state, writes to other addresses, a second line joining a shared edge request, and a route removed while its line is held.

// File: rtl/pirq_steer.sv
module pirq_steer #(
  parameter int AW = 8,
  parameter logic [AW-1:0] ROUTE_ADDR = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [3:0]    pci_int_n,
  output logic [15:0]   irq_req
);
  localparam int NLINE = 4;
  localparam int NIRQ = 16;
  localparam logic [AW-1:0] ADDR_HI = ROUTE_ADDR + 1'b1;
  localparam logic [NIRQ-1:0] TGT_MASK = 16'b1101_1110_0010_0000;

  logic [7:0] route_lo, route_hi;
  logic [3:0] fld [NLINE];
  logic [NIRQ-1:0] lvl, edge_mode, req_q, irq_q;
  logic wr_hit;

  assign wr_hit = wr_en && (wr_addr == ROUTE_ADDR || wr_addr == ADDR_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_lo <= 8'h80;
      route_hi <= 8'h00;
    end else if (wr_en) begin
      if (wr_addr == ROUTE_ADDR) route_lo <= wr_data;
      if (wr_addr == ADDR_HI)    route_hi <= wr_data;
    end
  end

  assign fld[0] = route_lo[3:0];
  assign fld[1] = route_lo[7:4];
  assign fld[2] = route_hi[3:0];
  assign fld[3] = route_hi[7:4];

  function automatic logic [3:0] tgt_of(input logic [2:0] idx);
    case (idx)
      3'd1: tgt_of = 4'd5;
      3'd2: tgt_of = 4'd9;
      3'd3: tgt_of = 4'd10;
      3'd4: tgt_of = 4'd11;
      3'd5: tgt_of = 4'd12;
      3'd6: tgt_of = 4'd14;
      3'd7: tgt_of = 4'd15;
      default: tgt_of = 4'd0;
    endcase
  endfunction

  always_comb begin
    lvl = '0;
    edge_mode = '0;
    for (int i = 0; i < NLINE; i++) begin
      if (fld[i][2:0] != 3'd0) begin
        lvl[tgt_of(fld[i][2:0])] = lvl[tgt_of(fld[i][2:0])] | ~pci_int_n[i];
        edge_mode[tgt_of(fld[i][2:0])] = edge_mode[tgt_of(fld[i][2:0])] | fld[i][3];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      irq_q <= '0;
    end else begin
      req_q <= lvl;
      irq_q <= (lvl & ~(edge_mode & req_q)) & TGT_MASK;
    end
  end

  assign irq_req = irq_q;

  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q & ~TGT_MASK) == '0);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (&pci_int_n) |=> (irq_q == '0));

  p_write_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ROUTE_ADDR) |=> (route_lo == $past(wr_data)));

  p_write_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_HI) |=> (route_hi == $past(wr_data)));

  p_no_write_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ($stable(route_lo) && $stable(route_hi)));

  for (genvar k = 0; k < NIRQ; k++) begin : g_chk
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q[k] && edge_mode[k] && !wr_hit) |=> !irq_q[k]);
    p_level_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_mode[k] && !wr_hit) |=> (irq_q[k] == ($past(lvl[k]) & TGT_MASK[k])));
  end
endmodule

// File: tb/sim_pirq_steer.sv
module sim_pirq_steer;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] wr_addr = 0, wr_data = 0;
  logic [3:0] pci_int_n = 4'hF;
  logic [15:0] irq_req;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pirq_steer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                 .wr_data(wr_data), .pci_int_n(pci_int_n), .irq_req(irq_req));

  function automatic int tnum(input int idx);
    if (idx == 1) return 5;
    if (idx <= 5) return idx + 7;
    return idx + 8;
  endfunction

  function automatic logic [3:0] fget(input logic [7:0] r0, input logic [7:0] r1, input int i);
    logic [15:0] both = {r1, r0};
    return both[4*i +: 4];
  endfunction

  function automatic logic [15:0] m_lvl(input logic [7:0] r0, input logic [7:0] r1, input logic [3:0] pat);
    logic [15:0] v = '0;
    for (int i = 0; i < 4; i++)
      if (fget(r0, r1, i)[2:0] != 0 && pat[i]) v[tnum(int'(fget(r0, r1, i)[2:0]))] = 1'b1;
    return v;
  endfunction

  function automatic logic [15:0] m_edge(input logic [7:0] r0, input logic [7:0] r1);
    logic [15:0] v = '0;
    for (int i = 0; i < 4; i++)
      if (fget(r0, r1, i)[2:0] != 0 && fget(r0, r1, i)[3]) v[tnum(int'(fget(r0, r1, i)[2:0]))] = 1'b1;
    return v;
  endfunction

  task automatic chk(input logic [15:0] exp, input string req);
    checks++;
    if (irq_req !== exp) begin
      errors++;
      $display("FAIL %s: irq_req=%h expected %h", req, irq_req, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [7:0] r1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 / R5: reset routes disabled although the INTB field has bit 3 set
    pci_int_n = 4'h0;
    step(); chk(16'h0, "R1"); step(); chk(16'h0, "R5");
    pci_int_n = 4'hF; step();

    // R2: other addresses ignored; level route INTA->IRQ5 holds
    wr(8'h80, 8'h01);
    wr(8'h82, 8'hFF); wr(8'h7F, 8'h00);
    pci_int_n = 4'hE;
    step(); chk(16'h0020, "R2"); step(); chk(16'h0020, "R7");
    pci_int_n = 4'hF; step(); chk(16'h0, "R7"); step();

    // R8: shared edge target, second line joins without a new pulse
    wr(8'h80, 8'h99);
    pci_int_n = 4'hE;
    step(); chk(16'h0020, "R8"); step(); chk(16'h0, "R8");
    pci_int_n = 4'hC;
    step(); chk(16'h0, "R8"); step(); chk(16'h0, "R8");
    pci_int_n = 4'hD;
    step(); chk(16'h0, "R8");
    pci_int_n = 4'hF; step(); step();

    // R10: remove an active level route
    wr(8'h80, 8'h01);
    pci_int_n = 4'hE;
    step(); chk(16'h0020, "R10");
    wr_en = 1; wr_addr = 8'h80; wr_data = 8'h00;
    @(posedge clk); @(negedge clk); wr_en = 0;
    chk(16'h0020, "R10");
    step(); chk(16'h0, "R10"); step(); chk(16'h0, "R10");
    pci_int_n = 4'hF; step(); step();

    // R3/R4/R6/R7/R8/R9 sweep
    for (int r0 = 0; r0 < 256; r0++) begin
      r1 = 8'((r0 * 37 + 11) & 255);
      wr(8'h80, 8'(r0)); wr(8'h81, r1);
      step();
      for (int p = 0; p < 16; p++) begin
        pci_int_n = ~4'(p);
        step(); chk(m_lvl(8'(r0), r1, 4'(p)), "R4");
        step(); chk(m_lvl(8'(r0), r1, 4'(p)) & ~m_edge(8'(r0), r1), "R8");
        pci_int_n = 4'hF;
        step(); chk(16'h0, "R6");
        step();
      end
    end
    finish_run();
  end
endmodule